// File: doc/BRIEF.md
# SDRAM Cache-Line Read Sequencer

This block turns a single read request into the command stream that a single-data-rate SDRAM needs to fill one four-word cache line. A request carries a bank, a row and a column. The block opens the row with an activate command. It then issues a read that closes the row by itself when the burst ends. It samples the four data words from the memory data bus and hands them back with a valid strobe and a beat index.

Every access uses the same closed-page sequence, so the cost of an access is fixed. A static input picks one of two timing sets. In the fast set the row-to-column delay and the CAS latency are both 2 cycles. In the slow set both are 3 cycles. Successive row openings are then 7 or 10 cycles apart. A free-running refresh timer raises a request at a fixed interval. The sequencer issues a refresh command once the current burst has drained. It holds off new accesses while the refresh is pending and while it runs.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block begins to act two clock edges after the release.

Top module: `cline_rd_seq`

## Requirements
- R1: During reset and right after it, sd_cmd is NOP, rsp_valid is low and req_ready is high.
- R2: A request is taken on a clock edge where req_valid and req_ready are both high. In the next cycle sd_cmd is ACT, with sd_ba equal to the bank and sd_addr equal to the row.
- R3: Exactly T cycles after each ACT, sd_cmd is READ, with T = 2 when cfg_slow = 0 and T = 3 when cfg_slow = 1. During the READ, sd_ba carries the bank and sd_addr[COL_W-1:0] carries the column. Bit 10 of sd_addr is 1, which requests automatic precharge. The remaining address bits are 0.
- R4: sd_dq is sampled T cycles after the READ and in each of the three cycles that follow. Each sample comes out on rsp_data one cycle later, with rsp_valid high. rsp_beat counts 0, 1, 2, 3 in burst order, and beat 0 is the word at the requested column.
- R5: After each ACT, req_ready stays low until the next ACT can be issued. When a request is waiting, the next ACT comes exactly 3T+1 cycles after the previous one, which is 7 or 10 cycles. It never comes sooner.
- R6: sd_cmd is driven as {cs_n, ras_n, cas_n, we_n} using four codes: NOP = 4'b0111, ACT = 4'b0011, READ = 4'b0101 and REFRESH = 4'b0001. Every cycle that carries no ACT, READ or REFRESH carries NOP.
- R7: A refresh becomes pending every RFSH_PERIOD cycles. It is served before any new request, so even under continuous requests, successive REFRESH commands (and the first one after reset) are at most RFSH_PERIOD+16 cycles apart.
- R8: A refresh occupies 3T+1 cycles. No ACT or REFRESH follows it sooner than 3T+1 cycles after the REFRESH command. req_ready is low for 3T cycles starting with the REFRESH cycle, and no beat is returned during that time.
- R9: A REFRESH command never appears until the last data word of the access in flight has been sampled from sd_dq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| cfg_slow | input | 1 | Timing set: 0 = 2:2:2, 1 = 3:3:3; change only while reset is asserted |
| req_valid | input | 1 | A read request is offered |
| req_ready | output | 1 | The block can take a request |
| req_bank | input | BA_W | Bank of the request |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the first word |
| sd_cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} command |
| sd_ba | output | BA_W | Bank address bus |
| sd_addr | output | ROW_W | Row or column address bus |
| sd_dq | input | DATA_W | Data from the memory |
| rsp_valid | output | 1 | A returned word is present |
| rsp_beat | output | 2 | Burst position of the returned word |
| rsp_data | output | DATA_W | Returned word |

## Verification
A sequencer counter that slips by one cycle moves the READ to the wrong slot relative to its ACT. That fault is visible on sd_cmd within T cycles of the activate. A capture window that is misaligned with the CAS latency returns a word at the wrong column. Because each address in the memory model holds a distinct value, that fault shows up in the first rsp_data beat, about 2T+1 cycles after the ACT. A refresh flag or drain tracker in the wrong state produces one of three faults: a REFRESH too soon after a command, a REFRESH on top of the burst's last word, or refreshes that stop under load. Each of these is caught at the REFRESH itself or within one refresh interval.

// File: rtl/cline_pkg.sv
package cline_pkg;

  typedef enum logic [3:0] {
    SD_NOP = 4'b0111,
    SD_ACT = 4'b0011,
    SD_RD  = 4'b0101,
    SD_REF = 4'b0001
  } sd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACC,
    ST_REF
  } seq_st_e;

  localparam int unsigned MAX_T   = 3;
  localparam int unsigned CNT_W   = $clog2(3 * MAX_T + 1);
  localparam int unsigned LAT_W   = $clog2(MAX_T + 4 + 1);
  localparam int unsigned BEATS   = 4;
  localparam int unsigned BEAT_W  = $clog2(BEATS);

endpackage

// File: rtl/cline_rfsh_tmr.sv
module cline_rfsh_tmr #(
  parameter int unsigned PERIOD = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pend
);
  localparam int unsigned TW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [TW-1:0] TOP = TW'(PERIOD - 1);

  logic [TW-1:0] tick_q, tick_n;
  logic          pend_q, pend_n;
  logic          fire;

  always_comb begin
    fire   = (tick_q == TOP);
    tick_n = fire ? '0 : tick_q + 1'b1;
    pend_n = fire | (pend_q & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      pend_q <= 1'b0;
    end else begin
      tick_q <= tick_n;
      pend_q <= pend_n;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/cline_seq_fsm.sv
module cline_seq_fsm
  import cline_pkg::*;
#(
  parameter int unsigned BA_W   = 2,
  parameter int unsigned ROW_W  = 13,
  parameter int unsigned COL_W  = 9,
  parameter int unsigned AP_BIT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_slow,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [BA_W-1:0]  req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             rf_pend,
  input  logic             data_busy,
  output logic             rf_ack,
  output sd_cmd_e          cmd,
  output logic [BA_W-1:0]  ba,
  output logic [ROW_W-1:0] addr
);
  seq_st_e          st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  sd_cmd_e          cmd_q, cmd_n;
  logic [BA_W-1:0]  ba_q, ba_n, bank_q;
  logic [ROW_W-1:0] addr_q, addr_n;
  logic [COL_W-1:0] col_q;
  logic             take;
  logic [CNT_W-1:0] t_cyc, t_last;

  always_comb begin
    t_cyc  = cfg_slow ? CNT_W'(3) : CNT_W'(2);
    t_last = (t_cyc << 1) + t_cyc - 1'b1;
  end

  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    cmd_n     = SD_NOP;
    ba_n      = '0;
    addr_n    = '0;
    rf_ack    = 1'b0;
    take      = 1'b0;
    req_ready = (st_q == ST_IDLE) && !rf_pend;
    unique case (st_q)
      ST_IDLE: begin
        if (rf_pend) begin
          if (!data_busy) begin
            st_n   = ST_REF;
            cnt_n  = '0;
            cmd_n  = SD_REF;
            rf_ack = 1'b1;
          end
        end else if (req_valid) begin
          take   = 1'b1;
          st_n   = ST_ACC;
          cnt_n  = '0;
          cmd_n  = SD_ACT;
          ba_n   = req_bank;
          addr_n = req_row;
        end
      end
      ST_ACC: begin
        cnt_n = cnt_q + 1'b1;
        if (cnt_q == t_cyc - 1'b1) begin
          cmd_n                = SD_RD;
          ba_n                 = bank_q;
          addr_n[COL_W-1:0]    = col_q;
          addr_n[AP_BIT]       = 1'b1;
        end
        if (cnt_q == t_last) st_n = ST_IDLE;
      end
      ST_REF: begin
        cnt_n = cnt_q + 1'b1;
        if (cnt_q == t_last) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      cmd_q  <= SD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      cmd_q  <= cmd_n;
      ba_q   <= ba_n;
      addr_q <= addr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      col_q  <= '0;
    end else if (take) begin
      bank_q <= req_bank;
      col_q  <= req_col;
    end
  end

  assign cmd  = cmd_q;
  assign ba   = ba_q;
  assign addr = addr_q;
endmodule

// File: rtl/cline_beat_cap.sv
module cline_beat_cap
  import cline_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_slow,
  input  logic              rd_issued,
  input  logic [DATA_W-1:0] sd_dq,
  output logic              busy,
  output logic              rsp_valid,
  output logic [BEAT_W-1:0] rsp_beat,
  output logic [DATA_W-1:0] rsp_data
);
  logic              busy_q, busy_n;
  logic [LAT_W-1:0]  lat_q, lat_n, cl;
  logic              v_q, v_n;
  logic [BEAT_W-1:0] beat_q, beat_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic              grab;

  always_comb begin
    cl     = cfg_slow ? LAT_W'(3) : LAT_W'(2);
    busy_n = busy_q;
    lat_n  = lat_q;
    v_n    = 1'b0;
    beat_n = beat_q;
    data_n = data_q;
    grab   = busy_q && (lat_q >= cl);
    if (rd_issued) begin
      busy_n = 1'b1;
      lat_n  = LAT_W'(1);
    end else if (busy_q) begin
      lat_n = lat_q + 1'b1;
      if (lat_q == cl + LAT_W'(BEATS - 1)) busy_n = 1'b0;
    end
    if (grab) begin
      v_n    = 1'b1;
      beat_n = BEAT_W'(lat_q - cl);
      data_n = sd_dq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      lat_q  <= '0;
      v_q    <= 1'b0;
      beat_q <= '0;
    end else begin
      busy_q <= busy_n;
      lat_q  <= lat_n;
      v_q    <= v_n;
      beat_q <= beat_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (grab) data_q <= data_n;
  end

  assign busy      = busy_q;
  assign rsp_valid = v_q;
  assign rsp_beat  = beat_q;
  assign rsp_data  = data_q;
endmodule

// File: rtl/cline_rd_seq.sv
module cline_rd_seq
  import cline_pkg::*;
#(
  parameter int unsigned BA_W        = 2,
  parameter int unsigned ROW_W       = 13,
  parameter int unsigned COL_W       = 9,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned AP_BIT      = 10,
  parameter int unsigned RFSH_PERIOD = 780,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_slow,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic [3:0]        sd_cmd,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  input  logic [DATA_W-1:0] sd_dq,
  output logic              rsp_valid,
  output logic [1:0]        rsp_beat,
  output logic [DATA_W-1:0] rsp_data
);
  logic [SYNC_STAGES-1:0] rst_sr;
  logic                   rst_core_n;
  logic                   rf_pend, rf_ack, data_busy;
  sd_cmd_e                cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr <= '0;
    else        rst_sr <= {rst_sr[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sr[SYNC_STAGES-1];

  cline_rfsh_tmr #(.PERIOD(RFSH_PERIOD)) u_tmr (
    .clk   (clk),
    .rst_n (rst_core_n),
    .ack   (rf_ack),
    .pend  (rf_pend)
  );

  cline_seq_fsm #(
    .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cfg_slow  (cfg_slow),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_bank  (req_bank),
    .req_row   (req_row),
    .req_col   (req_col),
    .rf_pend   (rf_pend),
    .data_busy (data_busy),
    .rf_ack    (rf_ack),
    .cmd       (cmd),
    .ba        (sd_ba),
    .addr      (sd_addr)
  );

  cline_beat_cap #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cfg_slow  (cfg_slow),
    .rd_issued (cmd == SD_RD),
    .sd_dq     (sd_dq),
    .busy      (data_busy),
    .rsp_valid (rsp_valid),
    .rsp_beat  (rsp_beat),
    .rsp_data  (rsp_data)
  );

  assign sd_cmd = cmd;
endmodule

// File: rtl/cline_rd_seq_chk.sv
module cline_rd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_slow,
  input logic       req_ready,
  input logic [3:0] sd_cmd,
  input logic       rsp_valid,
  input logic [1:0] rsp_beat
);
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_REF = 4'b0001;

  logic [3:0] gap_q, rw_q, span;
  logic       open_cmd;

  assign span     = cfg_slow ? 4'd10 : 4'd7;
  assign open_cmd = (sd_cmd == C_ACT) || (sd_cmd == C_REF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= 4'd15;
      rw_q  <= 4'd0;
    end else begin
      gap_q <= open_cmd ? 4'd1 : ((gap_q == 4'd15) ? gap_q : gap_q + 4'd1);
      rw_q  <= (sd_cmd == C_REF) ? 4'd1
             : ((rw_q != 4'd0 && rw_q < span - 4'd1) ? rw_q + 4'd1 : 4'd0);
    end
  end

  // R3
  a_r3_read_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == C_RD) |-> (cfg_slow ? ($past(sd_cmd, 3) == C_ACT) : ($past(sd_cmd, 2) == C_ACT)));

  // R4
  a_r4_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_beat != 2'd3) |=> (rsp_valid && rsp_beat == $past(rsp_beat) + 2'd1));

  a_r4_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (rsp_beat == 2'd0));

  // R5
  a_r5_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == C_ACT) |-> !req_ready);

  a_r5_open_gap: assert property (@(posedge clk) disable iff (!rst_n)
    open_cmd |-> (gap_q >= span));

  // R6
  a_r6_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == C_NOP) || open_cmd || (sd_cmd == C_RD));

  // R8
  a_r8_quiet_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    ((sd_cmd == C_REF) || rw_q != 4'd0) |-> !rsp_valid);
endmodule

bind cline_rd_seq cline_rd_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_slow  (cfg_slow),
  .req_ready (req_ready),
  .sd_cmd    (sd_cmd),
  .rsp_valid (rsp_valid),
  .rsp_beat  (rsp_beat)
);

// File: tb/tb_cline_rd_seq.sv
`timescale 1ns/1ps
module tb_cline_rd_seq;
  localparam int BA_W = 2, ROW_W = 13, COL_W = 9, DATA_W = 16, RFSH = 150, NREQ = 40;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101, C_REF = 4'b0001;

  logic clk = 1'b0, rst_n = 1'b0, cfg_slow = 1'b0, req_valid = 1'b0;
  logic req_ready, rsp_valid;
  logic [BA_W-1:0] req_bank = '0, sd_ba;
  logic [ROW_W-1:0] req_row = '0, sd_addr;
  logic [COL_W-1:0] req_col = '0;
  logic [3:0] sd_cmd;
  logic [DATA_W-1:0] sd_dq = '0, rsp_data;
  logic [1:0] rsp_beat;

  always #2 clk = ~clk;

  cline_rd_seq #(.BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
                 .RFSH_PERIOD(RFSH)) dut (.*);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  int q_ba [NREQ], q_row [NREQ], q_col [NREQ], acc_cyc [NREQ];
  int n_sent, n_act, act_idx, last_open, last_ref, last_rd, rd_idx, beat_exp, n_beats, n_ref;
  int m_ba, m_row, m_col, m_rd, cur_row;
  bit mon_on = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int pat(input int ba, input int row, input int col, input int k);
    return ((row * 7) ^ (col << 3) ^ (ba << 13) ^ (k * 16'h1111) ^ 16'h5A5A) & 16'hFFFF;
  endfunction

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // memory model and monitor
  always @(negedge clk) begin
    int tt, d;
    tt = cfg_slow ? 3 : 2;
    d = cyc - m_rd;
    if (mon_on && d >= tt && d < tt + 4) sd_dq <= DATA_W'(pat(m_ba, m_row, m_col, d - tt));
    else sd_dq <= 16'h0BAD;
    if (mon_on) begin
      case (sd_cmd)
        C_ACT: begin
          chk(cyc - last_open >= 3*tt + 1, "R5 act gap", cyc - last_open, 3*tt + 1);
          chk(!req_ready, "R5 ready low at act", int'(req_ready), 0);
          chk(n_act < n_sent, "R2 act without request", n_act, n_sent);
          if (n_act < n_sent) begin
            chk(cyc == acc_cyc[n_act] + 1, "R2 act cycle", cyc, acc_cyc[n_act] + 1);
            chk(int'(sd_ba) == q_ba[n_act] && int'(sd_addr) == q_row[n_act], "R2 act addr",
                int'(sd_addr), q_row[n_act]);
            if (n_act > 0 && acc_cyc[n_act] <= last_open + 3*tt)
              chk(cyc == last_open + 3*tt + 1, "R5 back-to-back act", cyc, last_open + 3*tt + 1);
          end
          cur_row = int'(sd_addr);
          act_idx = n_act; n_act++; last_open = cyc;
        end
        C_RD: begin
          chk(cyc == last_open + tt, "R3 read slot", cyc, last_open + tt);
          chk(int'(sd_ba) == q_ba[act_idx], "R3 read bank", int'(sd_ba), q_ba[act_idx]);
          chk(int'(sd_addr) == (q_col[act_idx] | 1024), "R3 read addr ap", int'(sd_addr),
              q_col[act_idx] | 1024);
          m_ba = int'(sd_ba); m_row = cur_row; m_col = int'(sd_addr[COL_W-1:0]); m_rd = cyc;
          last_rd = cyc; rd_idx = act_idx; beat_exp = 0;
        end
        C_REF: begin
          chk(cyc - last_open >= 3*tt + 1, "R8 ref gap", cyc - last_open, 3*tt + 1);
          chk(cyc > last_rd + tt + 3, "R9 ref after last word", cyc, last_rd + tt + 4);
          chk(cyc - last_ref <= RFSH + 16, "R7 ref interval", cyc - last_ref, RFSH + 16);
          last_ref = cyc; last_open = cyc; n_ref++;
        end
        C_NOP: ;
        default: chk(1'b0, "R6 command code", int'(sd_cmd), int'(C_NOP));
      endcase
      if (n_ref > 0 && cyc - last_ref >= 0 && cyc - last_ref < 3*tt)
        chk(!req_ready, "R8 ready low in refresh", int'(req_ready), 0);
      if (rsp_valid) begin
        chk(beat_exp < 4, "R4 extra beat", beat_exp, 3);
        chk(cyc == last_rd + tt + 1 + beat_exp, "R4 beat cycle", cyc, last_rd + tt + 1 + beat_exp);
        chk(int'(rsp_beat) == beat_exp, "R4 beat index", int'(rsp_beat), beat_exp);
        chk(int'(rsp_data) == pat(q_ba[rd_idx], q_row[rd_idx], q_col[rd_idx], beat_exp),
            "R4 beat data", int'(rsp_data), pat(q_ba[rd_idx], q_row[rd_idx], q_col[rd_idx], beat_exp));
        beat_exp++; n_beats++;
      end
      if (cyc - last_ref > RFSH + 16)
        chk(1'b0, "R7 refresh overdue", cyc - last_ref, RFSH + 16);
    end
  end

  task automatic send(input int i, input int gap);
    repeat (gap) @(negedge clk);
    q_ba[i] = i % 4;
    q_row[i] = (i == 1) ? 8191 : (i * 613) % 8192;
    q_col[i] = (i == 2) ? 511 : (i * 37 + i % 4) % 512;
    req_bank = BA_W'(q_ba[i]); req_row = ROW_W'(q_row[i]); req_col = COL_W'(q_col[i]);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    acc_cyc[i] = cyc; n_sent++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    for (int cfg = 0; cfg < 2; cfg++) begin
      mon_on = 1'b0;
      @(negedge clk);
      rst_n = 1'b0; cfg_slow = cfg[0];
      repeat (3) @(negedge clk);
      chk(sd_cmd == C_NOP && !rsp_valid, "R1 in reset", int'(sd_cmd), int'(C_NOP));
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(sd_cmd == C_NOP, "R1 cmd after reset", int'(sd_cmd), int'(C_NOP));
      chk(!rsp_valid, "R1 rsp after reset", int'(rsp_valid), 0);
      chk(req_ready, "R1 ready after reset", int'(req_ready), 1);
      n_sent = 0; n_act = 0; act_idx = 0; n_beats = 0; n_ref = 0; beat_exp = 4;
      last_open = cyc - 100; last_ref = cyc - 2; last_rd = cyc - 100; rd_idx = 0;
      m_rd = cyc - 100; mon_on = 1'b1;
      for (int i = 0; i < NREQ; i++) send(i, (i < NREQ/2) ? 0 : i % 5);
      repeat (RFSH + 40) @(negedge clk);
      chk(n_act == NREQ, "R2 act count", n_act, NREQ);
      chk(n_beats == 4*NREQ, "R4 beat count", n_beats, 4*NREQ);
      chk(n_ref >= 2, "R7 refresh count", n_ref, 2);
    end
    report();
  end
endmodule